// File: doc/BRIEF.md
# Display Controller Control Register File

This block is the software-visible control store of a display controller. A simple 32-bit bus (address, write enable, write data, read data) reaches five registers: a main control word, a secondary control word that carries the frame-done interrupt, a transfer-count word, and a pair of frame buffer addresses. Every register has three write views. The base offset replaces the implemented bits. Offset +4 ORs the written ones into the register. Offset +8 clears the bits that are one in the data. Software can therefore change one field without a read-modify-write sequence that races the hardware.

The hardware side drives two inputs. A one-cycle `frame_end` pulse latches the frame-done status and promotes the queued next buffer address into the current one. A `fifo_empty` level lets the run bit drop by itself once the pixel FIFO has drained after dot-clock mode has been switched off. The run bit is held by a small state machine with three states:
- RUN_IDLE (run reads 0)
- RUN_ACTIVE (running in dot-clock mode)
- RUN_DRAIN (dot-clock mode is off and run is waiting for the FIFO to empty)

Its transitions are:
- IDLE→ACTIVE when software sets run.
- ACTIVE→IDLE when software clears run.
- ACTIVE→DRAIN when the stored dot-clock bit is 0.
- DRAIN→IDLE on `fifo_empty` or when software clears run.
- Any state→IDLE during soft reset.

Top module: `dispctl_regfile`

## Requirements
- R1: After `rst_n` is released, every register reads 0, and `run_o`, `dotclk_o`, `fifo_clr_o`, `irq` and `cur_buf_o` are 0.
- R2: A write at a register's base offset replaces its implemented bits. Main control (offset 0x00) implements bit 0 run, bit 5 bus master, bit 17 dot-clock mode, bit 19 bypass count, bit 30 clock gate and bit 31 soft reset. Secondary control (0x10) implements bit 9 frame-done status, bit 13 frame-done interrupt enable and bit 21 FIFO clear. Unimplemented bits read 0.
- R3: A write at base+4 sets exactly the bits that are 1 in the data and leaves the others unchanged.
- R4: A write at base+8 clears exactly the bits that are 1 in the data and leaves the others unchanged.
- R5: The following writes change nothing, and a read at an unmapped offset returns 0:
  - a write at base+0xC;
  - a write to an unmapped 16-byte block (0x20, 0x60 and up);
  - a write with address bits [1:0] not equal to 0.
- R6: The transfer count is at 0x30, with the vertical count in [31:16] and the horizontal count in [15:0]. The current buffer address is at 0x40 and the next buffer address at 0x50. A read at any of the base, +4 or +8 offsets of a block returns that register's value.
- R7: A `frame_end` pulse sets the frame-done status at the next clock edge. The status stays set until software clears it.
- R8: When a `frame_end` pulse and a software clear of the status fall in the same cycle, the status is 1 afterwards.
- R9: `irq` is 1 exactly when both the frame-done status and its enable are 1.
- R10: At each `frame_end`, the current buffer address takes the value the next buffer address held before that edge. This promotion overrides a software write to the current address in the same cycle. A write to the next address in that cycle is stored only for the following frame.
- R11: Setting run starts the controller. `run_o` is 1 after that edge. Clearing run by a write stops it at the next edge.
- R12: If the stored dot-clock bit is 0 while running, run stays 1 while `fifo_empty` is 0. Run clears at the first edge, at least two edges after the clearing write, at which `fifo_empty` is 1.
- R13: While the stored soft-reset bit (0x00 bit 31) is 1:
  - every clock edge forces all register bits except control bits 31 and 30 to 0, including run;
  - bus writes reach only bits 31 and 30;
  - `frame_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: bits [7:4] pick the register, bits [3:2] pick the write view |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| frame_end | input | 1 | One-cycle end-of-frame pulse from the timing logic |
| fifo_empty | input | 1 | Pixel FIFO empty level |
| run_o | output | 1 | Controller run state |
| dotclk_o | output | 1 | Dot-clock mode bit |
| fifo_clr_o | output | 1 | FIFO clear bit |
| irq | output | 1 | Frame-done interrupt |
| cur_buf_o | output | 32 | Current frame buffer address |

## Verification
Each alias is exercised with data that has ones both inside and outside the implemented masks. This separates a correct masked OR or AND-NOT from a plain overwrite and from a decode that hits the wrong register. Collisions between `frame_end` and a status clear, a next-address write and a current-address write show whether hardware priority and the old-versus-new value of the next address are handled correctly. The drain run holds `fifo_empty` low for several cycles before raising it, which separates a run bit that waits for the FIFO from one that drops with the dot-clock bit. The soft-reset run writes and pulses `frame_end` while the reset bit is held, to show that only the two kept bits respond.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int DW   = 32;
    localparam int NREG = 5;

    // register indices inside the file
    localparam int IDX_CTRL  = 0;
    localparam int IDX_CTRL1 = 1;
    localparam int IDX_XFER  = 2;
    localparam int IDX_CUR   = 3;
    localparam int IDX_NEXT  = 4;

    // main control bit positions
    localparam int B_RUN     = 0;
    localparam int B_MASTER  = 5;
    localparam int B_DOTCLK  = 17;
    localparam int B_BYPASS  = 19;
    localparam int B_CLKGATE = 30;
    localparam int B_SRST    = 31;

    // secondary control bit positions
    localparam int B_FDONE    = 9;
    localparam int B_FDONE_EN = 13;
    localparam int B_FIFO_CLR = 21;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DRAIN  = 2'd2
    } run_state_e;

    // stored bits per register (run lives in the state machine)
    function automatic logic [DW-1:0] reg_mask(input int idx);
        logic [DW-1:0] m;
        m = '0;
        case (idx)
            IDX_CTRL: begin
                m[B_MASTER]  = 1'b1;
                m[B_DOTCLK]  = 1'b1;
                m[B_BYPASS]  = 1'b1;
                m[B_CLKGATE] = 1'b1;
                m[B_SRST]    = 1'b1;
            end
            IDX_CTRL1: begin
                m[B_FDONE]    = 1'b1;
                m[B_FDONE_EN] = 1'b1;
                m[B_FIFO_CLR] = 1'b1;
            end
            default: m = '1;
        endcase
        return m;
    endfunction

    // bits that survive a held soft reset
    function automatic logic [DW-1:0] reg_keep(input int idx);
        logic [DW-1:0] k;
        k = '0;
        if (idx == IDX_CTRL) begin
            k[B_CLKGATE] = 1'b1;
            k[B_SRST]    = 1'b1;
        end
        return k;
    endfunction

endpackage

// File: rtl/dispctl_addr_dec.sv
module dispctl_addr_dec
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              hit,
    output logic [2:0]        idx,
    output alias_op_e         op,
    output logic [NREG-1:0]   wr_stb
);
    localparam int BLK_W = ADDR_W - 4;

    logic [BLK_W-1:0] blk;
    logic             aligned;

    assign blk     = addr[ADDR_W-1:4];
    assign aligned = (addr[1:0] == 2'b00);
    assign op      = alias_op_e'(addr[3:2]);

    always_comb begin
        hit = aligned;
        idx = 3'd0;
        case (blk)
            BLK_W'(0): idx = 3'(IDX_CTRL);
            BLK_W'(1): idx = 3'(IDX_CTRL1);
            BLK_W'(3): idx = 3'(IDX_XFER);
            BLK_W'(4): idx = 3'(IDX_CUR);
            BLK_W'(5): idx = 3'(IDX_NEXT);
            default:   hit = 1'b0;
        endcase
    end

    always_comb begin
        wr_stb = '0;
        if (we && hit && (op != OP_NONE))
            wr_stb[idx] = 1'b1;
    end

endmodule

// File: rtl/dispctl_alias_reg.sv
module dispctl_alias_reg
    import dispctl_pkg::*;
#(
    parameter int            W    = 32,
    parameter logic [W-1:0]  MASK = '1,
    parameter logic [W-1:0]  KEEP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  alias_op_e     op,
    input  logic [W-1:0]  wdata,
    input  logic          zero_en,
    input  logic          hw_load_en,
    input  logic [W-1:0]  hw_load_val,
    input  logic [W-1:0]  hw_set,
    output logic [W-1:0]  q
);
    logic [W-1:0] applied;
    logic [W-1:0] nxt;

    always_comb begin
        applied = q;
        if (wr_en) begin
            unique case (op)
                OP_WRITE: applied = wdata;
                OP_SET:   applied = q | wdata;
                OP_CLEAR: applied = q & ~wdata;
                default:  applied = q;
            endcase
        end
        if (zero_en) begin
            nxt = applied & KEEP;
        end else begin
            nxt = hw_load_en ? hw_load_val : applied;
            nxt = nxt | hw_set;
        end
        nxt = nxt & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

endmodule

// File: rtl/dispctl_run_ctl.sv
module dispctl_run_ctl
    import dispctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr,
    input  alias_op_e op,
    input  logic      wd_run,
    input  logic      dotclk_q,
    input  logic      fifo_empty,
    input  logic      srst,
    output logic      run
);
    run_state_e state, state_nxt;
    logic       run_req;

    // run value a write would leave behind
    always_comb begin
        run_req = run;
        if (ctrl_wr) begin
            unique case (op)
                OP_WRITE: run_req = wd_run;
                OP_SET:   run_req = run | wd_run;
                OP_CLEAR: run_req = run & ~wd_run;
                default:  run_req = run;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RUN_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (srst) begin
            state_nxt = RUN_IDLE;
        end else begin
            unique case (state)
                RUN_IDLE:
                    if (run_req) state_nxt = RUN_ACTIVE;
                RUN_ACTIVE:
                    if (!run_req)      state_nxt = RUN_IDLE;
                    else if (!dotclk_q) state_nxt = RUN_DRAIN;
                RUN_DRAIN:
                    if (!run_req || fifo_empty) state_nxt = RUN_IDLE;
                default:
                    state_nxt = RUN_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            RUN_ACTIVE, RUN_DRAIN: run = 1'b1;
            default:               run = 1'b0;
        endcase
    end

endmodule

// File: rtl/dispctl_regfile.sv
module dispctl_regfile
    import dispctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              frame_end,
    input  logic              fifo_empty,
    output logic              run_o,
    output logic              dotclk_o,
    output logic              fifo_clr_o,
    output logic              irq,
    output logic [31:0]       cur_buf_o
);
    logic            hit;
    logic [2:0]      idx;
    alias_op_e       op;
    logic [NREG-1:0] wr_stb;

    logic [DW-1:0]   reg_q   [NREG];
    logic [DW-1:0]   hw_set  [NREG];
    logic [DW-1:0]   hw_val  [NREG];
    logic [NREG-1:0] hw_load;

    logic [DW-1:0] ctrl_q, ctrl1_q, xfer_q, cur_q, next_q;
    logic          srst_q;
    logic          run;

    dispctl_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .hit    (hit),
        .idx    (idx),
        .op     (op),
        .wr_stb (wr_stb)
    );

    assign ctrl_q  = reg_q[IDX_CTRL];
    assign ctrl1_q = reg_q[IDX_CTRL1];
    assign xfer_q  = reg_q[IDX_XFER];
    assign cur_q   = reg_q[IDX_CUR];
    assign next_q  = reg_q[IDX_NEXT];
    assign srst_q  = ctrl_q[B_SRST];

    // hardware side effects per register
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            hw_set[i] = '0;
            hw_val[i] = '0;
        end
        hw_load = '0;
        hw_set[IDX_CTRL1][B_FDONE] = frame_end;
        hw_load[IDX_CUR]           = frame_end;
        hw_val[IDX_CUR]            = next_q;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        dispctl_alias_reg #(
            .W    (DW),
            .MASK (reg_mask(g)),
            .KEEP (reg_keep(g))
        ) u_reg (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (wr_stb[g]),
            .op          (op),
            .wdata       (bus_wdata),
            .zero_en     (srst_q),
            .hw_load_en  (hw_load[g]),
            .hw_load_val (hw_val[g]),
            .hw_set      (hw_set[g]),
            .q           (reg_q[g])
        );
    end

    dispctl_run_ctl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_stb[IDX_CTRL]),
        .op         (op),
        .wd_run     (bus_wdata[B_RUN]),
        .dotclk_q   (ctrl_q[B_DOTCLK]),
        .fifo_empty (fifo_empty),
        .srst       (srst_q),
        .run        (run)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            if (idx == 3'(IDX_CTRL)) bus_rdata = ctrl_q | {{(DW-1){1'b0}}, run};
            else                     bus_rdata = reg_q[idx];
        end
    end

    assign run_o      = run;
    assign dotclk_o   = ctrl_q[B_DOTCLK];
    assign fifo_clr_o = ctrl1_q[B_FIFO_CLR];
    assign irq        = ctrl1_q[B_FDONE] & ctrl1_q[B_FDONE_EN];
    assign cur_buf_o  = cur_q;

endmodule

// File: rtl/dispctl_chk.sv
module dispctl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              frame_end,
    input logic              fifo_empty,
    input logic              run_o,
    input logic              dotclk_o,
    input logic              irq,
    input logic [31:0]       cur_buf_o,
    input logic              srst_q,
    input logic              status_q,
    input logic [31:0]       ctrl_q,
    input logic [31:0]       xfer_q,
    input logic [31:0]       next_q
);
    // R7
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !srst_q) |=> status_q);

    // R10
    promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !srst_q) |=> (cur_buf_o == $past(next_q)));

    // R12
    run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_o) |-> $past(fifo_empty || srst_q ||
                               (bus_we && bus_addr[ADDR_W-1:4] == '0)));

    // R13
    srst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (ctrl_q[29:0] == '0 && xfer_q == '0 && next_q == '0 &&
                    cur_buf_o == '0 && !status_q && !run_o));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_end || bus_we));

    // R2
    dotclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && !srst_q) |=> $stable(dotclk_o));

endmodule

bind dispctl_regfile dispctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .frame_end  (frame_end),
    .fifo_empty (fifo_empty),
    .run_o      (run_o),
    .dotclk_o   (dotclk_o),
    .irq        (irq),
    .cur_buf_o  (cur_buf_o),
    .srst_q     (srst_q),
    .status_q   (ctrl1_q[9]),
    .ctrl_q     (ctrl_q),
    .xfer_q     (xfer_q),
    .next_q     (next_q)
);

// File: tb/sim_dispctl_regfile.sv
module sim_dispctl_regfile;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CTRL_M  = 32'hC00A_0020;
    localparam logic [31:0] CTRL1_M = 32'h0020_2200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_end = 1'b0;
    logic        fifo_empty = 1'b1;
    logic        run_o, dotclk_o, fifo_clr_o, irq;
    logic [31:0] cur_buf_o;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // reference state
    logic [31:0] m_ctrl = '0, m_ctrl1 = '0, m_xfer = '0, m_cur = '0, m_next = '0;
    int          m_rs = 0;  // 0 idle, 1 active, 2 drain

    always #(CLK_PERIOD/2) clk = ~clk;

    dispctl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_end(frame_end),
        .fifo_empty(fifo_empty), .run_o(run_o), .dotclk_o(dotclk_o),
        .fifo_clr_o(fifo_clr_o), .irq(irq), .cur_buf_o(cur_buf_o)
    );

    function automatic logic [31:0] apv(logic [31:0] q, logic [31:0] w, int op);
        if (op == 0) return w;
        if (op == 1) return q | w;
        if (op == 2) return q & ~w;
        return q;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a[1:0] != 0) return 0;
        case (a[7:4])
            4'd0: return m_ctrl | ((m_rs != 0) ? 32'd1 : 32'd0);
            4'd1: return m_ctrl1;
            4'd3: return m_xfer;
            4'd4: return m_cur;
            4'd5: return m_next;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // advance the reference model by one edge using the current inputs
    task automatic model_step();
        int          op;
        int          blk;
        logic        wr;
        logic        srst;
        logic        rreq;
        logic        cur_run;
        logic [31:0] n_ctrl, n_ctrl1, n_xfer, n_cur, n_next, ap;
        op   = int'(bus_addr[3:2]);
        blk  = int'(bus_addr[7:4]);
        wr   = bus_we && (bus_addr[1:0] == 0) && (op != 3);
        srst = m_ctrl[31];
        cur_run = (m_rs != 0);
        n_ctrl = m_ctrl; n_ctrl1 = m_ctrl1; n_xfer = m_xfer; n_cur = m_cur; n_next = m_next;
        rreq = cur_run;
        if (wr && blk == 0) begin
            ap = apv(m_ctrl | {31'd0, cur_run}, bus_wdata, op);
            rreq = ap[0];
            n_ctrl = ap & CTRL_M;
        end
        if (wr && blk == 1) n_ctrl1 = apv(m_ctrl1, bus_wdata, op) & CTRL1_M;
        if (wr && blk == 3) n_xfer  = apv(m_xfer,  bus_wdata, op);
        if (wr && blk == 4) n_cur   = apv(m_cur,   bus_wdata, op);
        if (wr && blk == 5) n_next  = apv(m_next,  bus_wdata, op);
        if (srst) begin
            n_ctrl &= 32'hC000_0000;
            n_ctrl1 = 0; n_xfer = 0; n_cur = 0; n_next = 0;
            m_rs = 0;
        end else begin
            if (frame_end) begin
                n_ctrl1[9] = 1'b1;
                n_cur = m_next;
            end
            case (m_rs)
                0: if (rreq) m_rs = 1;
                1: if (!rreq) m_rs = 0; else if (!m_ctrl[17]) m_rs = 2;
                default: if (!rreq || fifo_empty) m_rs = 0;
            endcase
        end
        m_ctrl = n_ctrl; m_ctrl1 = n_ctrl1; m_xfer = n_xfer; m_cur = n_cur; m_next = n_next;
    endtask

    task automatic compare_outputs();
        check(cur_req, "run_o",      {31'd0, run_o},      {31'd0, m_rs != 0});
        check(cur_req, "dotclk_o",   {31'd0, dotclk_o},   {31'd0, m_ctrl[17]});
        check(cur_req, "fifo_clr_o", {31'd0, fifo_clr_o}, {31'd0, m_ctrl1[21]});
        check(cur_req, "irq",        {31'd0, irq},        {31'd0, m_ctrl1[9] & m_ctrl1[13]});
        check(cur_req, "cur_buf_o",  cur_buf_o,           m_cur);
    endtask

    task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic fe, logic fem);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; frame_end = fe; fifo_empty = fem;
        model_step();
        @(posedge clk);
        #1;
        compare_outputs();
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; frame_end = 1'b0;
        #1;
        check(req, $sformatf("read @%h vs model", a), bus_rdata, m_read(a));
        check(req, $sformatf("read @%h", a), bus_rdata, exp);
        model_step();
        @(posedge clk);
        #1;
        compare_outputs();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        cur_req = "R1";
        compare_outputs();
        rd(8'h00, 32'h0, "R1");
        rd(8'h10, 32'h0, "R1");
        rd(8'h40, 32'h0, "R1");

        // R2 direct write with stray bits; R11 run starts
        cur_req = "R2";
        cyc(1, 8'h00, 32'h400A_0F21, 0, 0);
        rd(8'h00, 32'h400A_0021, "R2");
        check("R11", "run_o after set", {31'd0, run_o}, 32'd1);
        cyc(1, 8'h10, 32'hFFDF_DDFF, 0, 0);
        rd(8'h10, 32'h0, "R2");

        // R3 set alias
        cur_req = "R3";
        cyc(1, 8'h14, 32'h0020_2000, 0, 0);
        rd(8'h10, 32'h0020_2000, "R3");
        cyc(1, 8'h04, 32'h0000_0020, 0, 0);
        rd(8'h00, 32'h400A_0021, "R3");

        // R7 / R9 frame done and interrupt
        cur_req = "R7";
        cyc(0, 8'h00, 32'h0, 1, 0);
        rd(8'h10, 32'h0020_2200, "R7");
        check("R9", "irq with status and enable", {31'd0, irq}, 32'd1);
        rd(8'h10, 32'h0020_2200, "R7");

        // R8 clear colliding with frame end
        cur_req = "R8";
        cyc(1, 8'h18, 32'h0000_0200, 1, 0);
        rd(8'h10, 32'h0020_2200, "R8");
        // R4 clear alias
        cur_req = "R4";
        cyc(1, 8'h18, 32'h0020_0200, 0, 0);
        rd(8'h10, 32'h0000_2000, "R4");
        check("R9", "irq after status clear", {31'd0, irq}, 32'd0);
        cyc(1, 8'h18, 32'h0000_2000, 1, 0);
        check("R9", "irq with enable off", {31'd0, irq}, 32'd0);

        // R6 map and aliases
        cur_req = "R6";
        cyc(1, 8'h30, 32'h01E0_0280, 0, 0);
        rd(8'h34, 32'h01E0_0280, "R6");
        rd(8'h38, 32'h01E0_0280, "R6");
        cyc(1, 8'h50, 32'hA000_0000, 0, 0);
        rd(8'h50, 32'hA000_0000, "R6");

        // R5 ignored writes
        cur_req = "R5";
        cyc(1, 8'h3C, 32'hFFFF_FFFF, 0, 0);
        cyc(1, 8'h31, 32'h0000_0000, 0, 0);
        cyc(1, 8'h60, 32'h1234_5678, 0, 0);
        cyc(1, 8'h20, 32'h1234_5678, 0, 0);
        rd(8'h30, 32'h01E0_0280, "R5");
        rd(8'h60, 32'h0, "R5");
        rd(8'h20, 32'h0, "R5");

        // R10 buffer promotion
        cur_req = "R10";
        cyc(1, 8'h50, 32'hB000_0000, 1, 0);
        check("R10", "cur gets old next", cur_buf_o, 32'hA000_0000);
        cyc(1, 8'h40, 32'hC000_0000, 1, 0);
        check("R10", "promotion beats cur write", cur_buf_o, 32'hB000_0000);
        cyc(1, 8'h40, 32'hC000_0000, 0, 0);
        check("R10", "plain cur write", cur_buf_o, 32'hC000_0000);

        // R12 drain
        cur_req = "R12";
        cyc(1, 8'h08, 32'h0002_0000, 0, 0);
        cyc(0, 8'h00, 32'h0, 0, 0);
        cyc(0, 8'h00, 32'h0, 0, 0);
        check("R12", "run held while FIFO busy", {31'd0, run_o}, 32'd1);
        cyc(0, 8'h00, 32'h0, 0, 1);
        check("R12", "run cleared after drain", {31'd0, run_o}, 32'd0);

        // R11 start and explicit stop
        cur_req = "R11";
        cyc(1, 8'h04, 32'h0002_0001, 0, 1);
        cyc(0, 8'h00, 32'h0, 0, 1);
        check("R11", "run stays in dot-clock mode", {31'd0, run_o}, 32'd1);
        cyc(1, 8'h08, 32'h0000_0001, 0, 0);
        check("R11", "run cleared by write", {31'd0, run_o}, 32'd0);

        // R13 soft reset
        cur_req = "R13";
        cyc(1, 8'h04, 32'h8000_0001, 0, 1);
        cyc(0, 8'h00, 32'h0, 1, 1);
        cyc(1, 8'h30, 32'h0000_1234, 1, 1);
        cyc(1, 8'h04, 32'h4000_0021, 0, 1);
        rd(8'h00, 32'hC000_0000, "R13");
        rd(8'h30, 32'h0, "R13");
        cyc(1, 8'h08, 32'h8000_0000, 0, 1);
        rd(8'h00, 32'h4000_0000, "R13");
        rd(8'h40, 32'h0, "R13");
        rd(8'h10, 32'h0, "R13");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule